// File: doc/BRIEF.md
# Packed Vector Integer Add Sequencer

This block runs a single-width vector integer add over a group of vector registers held in its own 32-entry register file. Each register is VLEN bits wide and is kept as VLEN/32 words of 32 bits. A command gives the destination register, the first source register, the second operand and its mode, the element-width field of the vector type, and the element count. The element width is chosen at run time. Elements are packed 4, 2 or 1 to a word, and no carry crosses between them. The sequencer processes one word per clock. After the last word of a register it moves on to word 0 of the next register in the group. A final word that is only partly covered is written only in its active lanes.

A host can load and read any register word through a one-word write port and a one-word read port. These ports act only while the sequencer is idle.

The controller has three states:
- IDLE: waiting for a command.
- RUN: one word per cycle.
- FIN: the one-cycle done pulse.

Its transitions are:
- LAUNCH: IDLE to RUN, on start with a supported width and a nonzero count.
- SKIP: IDLE to FIN, on start with an unsupported width or a zero count.
- STEP: RUN to RUN, after writing a word that is not the last.
- LAST: RUN to FIN, after writing the final word.
- ABORT: RUN to FIN, when the destination register number passes 31.
- RETIRE: FIN to IDLE.

Top module: `vadd_seq`

## Requirements
- R1: The width code is vtype bits [5:3]. Codes 0, 1 and 2 select 8, 16 and 32-bit elements. Any other code (3 to 7) writes nothing, leaves err low, and pulses done one cycle after start.
- R2: At 8 and 16 bits, element k of a word sits at bits k*SEW upward. Each element sum is kept modulo 2^SEW, and no carry enters the next element.
- R3: Mode 0 (vector-vector) adds the element of the vs2 group to the matching element of the vs1 group.
- R4: Mode 1 (vector-scalar) adds the 32-bit scalar input, truncated to SEW, to every vs2 element.
- R5: Mode 2 (vector-immediate) adds the 5-bit immediate, sign-extended to SEW, to every vs2 element.
- R6: Mode 3 (move-immediate) writes the sign-extended 5-bit immediate, truncated to SEW, into every active element, whatever the vs2 contents.
- R7: Elements are processed in increasing index order. After word VLEN/32-1 of register r, processing continues with word 0 of register r+1. Source register numbers wrap modulo 32.
- R8: Exactly vl elements are written. In a partly covered final word, the lanes at or above vl keep their old value. Later words and all other registers are untouched.
- R9: When the next destination register number would be above 31, err goes high and the operation ends without writing that register. Words written earlier keep their results. err stays high until the next accepted start.
- R10: busy is high from the cycle after an accepted start until done has been shown. done is high for exactly one cycle, n+1 cycles after start, where n is the number of words written (n+2 on an abort). A start while busy is ignored.
- R11: A vl of 0 writes nothing and pulses done one cycle after start.
- R12: host_rdata shows the addressed word combinationally. A host write lands while idle and is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| cmd_mode | input | 2 | 0 vector-vector, 1 vector-scalar, 2 vector-immediate, 3 move-immediate |
| cmd_vd | input | 5 | Destination register of the group |
| cmd_vs2 | input | 5 | First source register of the group |
| cmd_vs1 | input | 5 | Second source register (mode 0) |
| cmd_scalar | input | 32 | Scalar operand (mode 1) |
| cmd_imm | input | 5 | Signed immediate (modes 2, 3) |
| cmd_vtype | input | 8 | Vector type; bits [5:3] select the width |
| cmd_vl | input | VL_W | Number of elements |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command aborted on register overflow |
| host_we | input | 1 | Host word write enable |
| host_reg | input | 5 | Host register index |
| host_word | input | WB | Host word index within the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at host_reg/host_word |

## Verification
The hardest state to reach is the middle of a run, when both a competing start and a host write arrive. Showing that they are ignored needs a group long enough to keep the sequencer busy for several cycles. The bench launches multi-word commands and injects both disturbances on the first busy cycle. It then reads back the full register file to confirm that neither took effect. Boundary lengths are swept for every width and mode: one word, exact register, one past a register, and partly filled final words. A group placed at v30 drives the overflow abort.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

    typedef enum logic [1:0] {
        OP_VV = 2'd0,
        OP_VX = 2'd1,
        OP_VI = 2'd2,
        OP_MV = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    // Element width code: log2 of element bytes (0: 8b, 1: 16b, 2: 32b)
    function automatic logic [31:0] splat(input logic [31:0] s, input logic [1:0] ew);
        unique case (ew)
            2'd0:    splat = {4{s[7:0]}};
            2'd1:    splat = {2{s[15:0]}};
            default: splat = s;
        endcase
    endfunction

endpackage

// File: rtl/vadd_rf.sv
module vadd_rf #(
    parameter int NREG = 32,
    parameter int WPR  = 4,
    localparam int AW  = $clog2(NREG * WPR)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [31:0]   rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [31:0]   rdata_b,
    input  logic [AW-1:0] raddr_c,
    output logic [31:0]   rdata_c,
    input  logic [AW-1:0] raddr_h,
    output logic [31:0]   rdata_h
);
    logic [31:0] mem [NREG*WPR];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
    assign rdata_c = mem[raddr_c];
    assign rdata_h = mem[raddr_h];
endmodule

// File: rtl/vadd_lanes.sv
module vadd_lanes (
    input  logic [31:0] a,
    input  logic [31:0] b,
    input  logic [1:0]  ew,
    output logic [31:0] sum
);
    logic [3:0] cy;

    for (genvar k = 0; k < 4; k++) begin : g_byte
        logic       link;
        logic       cin;
        logic [8:0] t;
        if (k == 0) begin : g_first
            assign link = 1'b0;
        end else if (k == 2) begin : g_mid
            assign link = (ew == 2'd2);
        end else begin : g_odd
            assign link = (ew != 2'd0);
        end
        assign cin = (k == 0) ? 1'b0 : (link & cy[(k == 0) ? 0 : k-1]);
        assign t = {1'b0, a[8*k +: 8]} + {1'b0, b[8*k +: 8]} + {8'd0, cin};
        assign sum[8*k +: 8] = t[7:0];
        assign cy[k] = t[8];
    end

    always_comb begin
        if (ew == 2'd0)
            a_r2_byte_iso: assert (sum[31:24] == 8'(a[31:24] + b[31:24]));
        if (ew == 2'd1)
            a_r2_half_iso: assert (sum[31:16] == 16'(a[31:16] + b[31:16]));
    end
endmodule

// File: rtl/vadd_seq.sv
module vadd_seq
    import vadd_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREG  = 32,
    localparam int WPR  = VLEN / 32,
    localparam int WB   = (WPR > 1) ? $clog2(WPR) : 1,
    localparam int RB   = $clog2(NREG),
    localparam int AW   = $clog2(NREG * WPR),
    localparam int VL_W = $clog2(VLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      cmd_mode,
    input  logic [RB-1:0]   cmd_vd,
    input  logic [RB-1:0]   cmd_vs2,
    input  logic [RB-1:0]   cmd_vs1,
    input  logic [31:0]     cmd_scalar,
    input  logic [4:0]      cmd_imm,
    input  logic [7:0]      cmd_vtype,
    input  logic [VL_W-1:0] cmd_vl,
    output logic            busy,
    output logic            done,
    output logic            err,
    input  logic            host_we,
    input  logic [RB-1:0]   host_reg,
    input  logic [WB-1:0]   host_word,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata
);
    seq_state_e state_q, state_d;
    op_mode_e   mode_q;
    logic [RB-1:0]   vd_q, vs2_q, vs1_q;
    logic [31:0]     opnd_q;
    logic [1:0]      ew_q;
    logic [VL_W-1:0] rem_q;
    logic [RB:0]     grp_q;
    logic [WB-1:0]   word_q;
    logic            err_q;

    logic [2:0]  code;
    logic        code_ok;
    logic        launch;
    logic [RB:0] dreg;
    logic        ovf;
    logic [RB-1:0] s2reg, s1reg;
    logic [VL_W-1:0] epw;
    logic        last;
    logic [3:0]  bm;
    logic [31:0] wmask;
    logic [31:0] rd_a, rd_b, rd_old;
    logic [31:0] lane_a, lane_b, lane_sum, merged;
    logic        eng_we;
    logic        rf_we;
    logic [AW-1:0] rf_waddr;
    logic [31:0] rf_wdata;

    // ---------------- command decode ----------------
    assign code    = cmd_vtype[5:3];
    assign code_ok = (code <= 3'd2);
    assign launch  = start && (state_q == ST_IDLE);

    // ---------------- word walker ----------------
    assign dreg  = {1'b0, vd_q} + grp_q;
    assign ovf   = dreg[RB];
    assign s2reg = vs2_q + grp_q[RB-1:0];
    assign s1reg = vs1_q + grp_q[RB-1:0];
    assign epw   = VL_W'(3'd4 >> ew_q);
    assign last  = (rem_q <= epw);

    for (genvar bi = 0; bi < 4; bi++) begin : g_bmask
        assign bm[bi] = VL_W'(3'(bi) >> ew_q) < rem_q;
        assign wmask[8*bi +: 8] = {8{bm[bi]}};
    end

    // ---------------- datapath ----------------
    vadd_rf #(.NREG(NREG), .WPR(WPR)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a ({s2reg, word_q}),
        .rdata_a (rd_a),
        .raddr_b ({s1reg, word_q}),
        .rdata_b (rd_b),
        .raddr_c ({dreg[RB-1:0], word_q}),
        .rdata_c (rd_old),
        .raddr_h ({host_reg, host_word}),
        .rdata_h (host_rdata)
    );

    assign lane_a = (mode_q == OP_MV) ? 32'd0 : rd_a;
    assign lane_b = (mode_q == OP_VV) ? rd_b : opnd_q;

    vadd_lanes u_lanes (
        .a   (lane_a),
        .b   (lane_b),
        .ew  (ew_q),
        .sum (lane_sum)
    );

    assign merged = (lane_sum & wmask) | (rd_old & ~wmask);
    assign eng_we = (state_q == ST_RUN) && !ovf;

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = {host_reg, host_word};
        rf_wdata = host_wdata;
        if (eng_we) begin
            rf_we    = 1'b1;
            rf_waddr = {dreg[RB-1:0], word_q};
            rf_wdata = merged;
        end else if (state_q == ST_IDLE && host_we) begin
            rf_we = 1'b1;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (code_ok && cmd_vl != '0) ? ST_RUN : ST_FIN;
            ST_RUN:  if (ovf || last) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- command and walker registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= OP_VV;
            vd_q   <= '0;
            vs2_q  <= '0;
            vs1_q  <= '0;
            opnd_q <= '0;
            ew_q   <= '0;
            rem_q  <= '0;
            grp_q  <= '0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else if (launch) begin
            mode_q <= op_mode_e'(cmd_mode);
            vd_q   <= cmd_vd;
            vs2_q  <= cmd_vs2;
            vs1_q  <= cmd_vs1;
            ew_q   <= code[1:0];
            opnd_q <= (op_mode_e'(cmd_mode) == OP_VX)
                      ? splat(cmd_scalar, code[1:0])
                      : splat({{27{cmd_imm[4]}}, cmd_imm}, code[1:0]);
            rem_q  <= cmd_vl;
            grp_q  <= '0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else if (state_q == ST_RUN) begin
            if (ovf) begin
                err_q <= 1'b1;
            end else if (!last) begin
                rem_q <= rem_q - epw;
                if (word_q == WB'(WPR - 1)) begin
                    word_q <= '0;
                    grp_q  <= grp_q + 1'b1;
                end else begin
                    word_q <= word_q + 1'b1;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_FIN);
        err  = err_q;
    end

    // ---------------- assertions ----------------
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r9_no_write_past_31: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && dreg > (RB+1)'(NREG - 1)) |-> !(rf_we && !host_we) && !eng_we);

    a_r12_host_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (busy ? (state_q == ST_RUN) : host_we));

    a_r8_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last && !ovf) |=> (rem_q < $past(rem_q)));

    a_r11_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_vl == '0) |=> done);
endmodule

// File: tb/tb_vadd_seq.sv
`timescale 1ns/1ps
module tb_vadd_seq;
    localparam int VLEN = 128;
    localparam int WPR  = VLEN / 32;
    localparam int NW   = 32 * WPR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd_mode = '0;
    logic [4:0]  cmd_vd = '0, cmd_vs2 = '0, cmd_vs1 = '0;
    logic [31:0] cmd_scalar = '0;
    logic [4:0]  cmd_imm = '0;
    logic [7:0]  cmd_vtype = '0;
    logic [7:0]  cmd_vl = '0;
    logic        busy, done, err;
    logic        host_we = 1'b0;
    logic [4:0]  host_reg = '0;
    logic [1:0]  host_word = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] mdl [NW];

    always #4 clk = ~clk;

    vadd_seq #(.VLEN(VLEN)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_mode(cmd_mode),
        .cmd_vd(cmd_vd), .cmd_vs2(cmd_vs2), .cmd_vs1(cmd_vs1),
        .cmd_scalar(cmd_scalar), .cmd_imm(cmd_imm), .cmd_vtype(cmd_vtype),
        .cmd_vl(cmd_vl), .busy(busy), .done(done), .err(err),
        .host_we(host_we), .host_reg(host_reg), .host_word(host_word),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_reg = 5'(addr / WPR); host_word = 2'(addr % WPR); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        mdl[addr] = d;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NW; i++) begin
            host_reg = 5'(i / WPR); host_word = 2'(i % WPR);
            #0.1;
            chk(host_rdata === mdl[i], tag, host_rdata, mdl[i]);
        end
    endtask

    task automatic run_op(input int mode, input int vd, input int vs2, input int vs1,
                          input logic [31:0] scal, input logic [4:0] imm, input int code,
                          input int vl, input bit disturb, input string tag);
        int ew, sew, epw, e, g, lat, exp_lat, dr, wd;
        bit exp_err;
        logic [31:0] msk, opnd, a, bv, nw, la, lb, r;
        exp_err = 1'b0;
        g = 0;
        if (code <= 2 && vl != 0) begin
            ew = code; sew = 8 << ew; epw = 4 >> ew;
            msk = (sew == 32) ? 32'hFFFF_FFFF : ((32'd1 << sew) - 32'd1);
            opnd = (mode == 1) ? scal : {{27{imm[4]}}, imm};
            e = 0;
            while (e < vl) begin
                dr = vd + g / WPR; wd = g % WPR;
                if (dr > 31) begin exp_err = 1'b1; break; end
                a  = mdl[((vs2 + g / WPR) % 32) * WPR + wd];
                bv = mdl[((vs1 + g / WPR) % 32) * WPR + wd];
                nw = mdl[dr * WPR + wd];
                for (int k = 0; k < epw && e < vl; k++) begin
                    la = (mode == 3) ? 32'd0 : ((a >> (k * sew)) & msk);
                    lb = (mode == 0) ? ((bv >> (k * sew)) & msk) : (opnd & msk);
                    r  = (la + lb) & msk;
                    nw = (nw & ~(msk << (k * sew))) | (r << (k * sew));
                    e++;
                end
                mdl[dr * WPR + wd] = nw;
                g++;
            end
        end
        exp_lat = exp_err ? g + 2 : g + 1;

        @(negedge clk);
        cmd_mode = 2'(mode); cmd_vd = 5'(vd); cmd_vs2 = 5'(vs2); cmd_vs1 = 5'(vs1);
        cmd_scalar = scal; cmd_imm = imm; cmd_vtype = {2'b00, 3'(code), 3'b000};
        cmd_vl = 8'(vl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (disturb && !done) begin
            // R10: competing start mid-run; R12: host write mid-run
            chk(busy === 1'b1, "R10 busy during run", 32'(busy), 32'd1);
            start = 1'b1; cmd_vd = 5'd0;
            host_we = 1'b1; host_reg = 5'd31; host_word = 2'd3; host_wdata = ~mdl[31*WPR+3];
        end
        while (!done && lat < 300) begin
            @(negedge clk);
            start = 1'b0; host_we = 1'b0;
            lat++;
        end
        start = 1'b0; host_we = 1'b0;
        chk(lat == exp_lat, {"R10 latency ", tag}, 32'(lat), 32'(exp_lat));
        chk(err === exp_err, {"R9 err flag ", tag}, 32'(err), 32'(exp_err));
        @(negedge clk);
        chk(done === 1'b0, "R10 done single pulse", 32'(done), 32'd0);
        check_all(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(7));
        #20;
        chk({busy, done, err} === 3'b000, "reset outputs", 32'({busy, done, err}), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) host_wr(i, $urandom());
        check_all("R12 host load/read");

        // R2: carry isolation, directed words
        host_wr(1 * WPR + 0, 32'h80FF_7FFF);
        host_wr(1 * WPR + 1, 32'hFFFF_FFFF);
        run_op(1, 2, 1, 0, 32'h0000_0101, 5'd0, 0, 8, 1'b0, "R2 byte carry");
        run_op(1, 3, 1, 0, 32'h0000_0001, 5'd0, 1, 4, 1'b0, "R2 half carry");
        run_op(1, 4, 1, 0, 32'h0000_0001, 5'd0, 2, 2, 1'b0, "R2 word carry");

        // Sweep widths x modes x lengths (R3..R8)
        for (int c = 0; c < 3; c++) begin
            for (int m = 0; m < 4; m++) begin
                for (int li = 0; li < 9; li++) begin
                    int epw, vl;
                    string t;
                    epw = 4 >> c;
                    case (li)
                        0: vl = 1;
                        1: vl = 2;
                        2: vl = 3;
                        3: vl = epw + 1;
                        4: vl = epw * WPR - 1;
                        5: vl = epw * WPR;
                        6: vl = epw * WPR + 1;
                        7: vl = 2 * epw * WPR - 1;
                        default: vl = 3 * epw * WPR;
                    endcase
                    case (m)
                        0: t = "R3 vv R7 R8";
                        1: t = "R4 vx R7 R8";
                        2: t = "R5 vi R7 R8";
                        default: t = "R6 mv R7 R8";
                    endcase
                    run_op(m, 2 + (li % 5) * 4, ($urandom() % 32), ($urandom() % 32),
                           $urandom(), 5'($urandom()), c, vl, 1'b0, t);
                end
            end
        end

        // R7: source group wraps past v31
        run_op(0, 4, 31, 30, 32'd0, 5'd0, 2, 3 * WPR, 1'b0, "R7 src wrap");
        // R1: unsupported width codes
        run_op(1, 2, 3, 4, 32'h1234_5678, 5'd3, 3, 8, 1'b0, "R1 code3 noop");
        run_op(2, 2, 3, 4, 32'h0, 5'd7, 7, 8, 1'b0, "R1 code7 noop");
        // R11: zero length
        run_op(0, 2, 3, 4, 32'h0, 5'd0, 0, 0, 1'b0, "R11 vl zero");
        // R9: destination overflow abort
        run_op(1, 30, 2, 0, 32'h1111_1111, 5'd0, 2, 3 * WPR, 1'b0, "R9 overflow");
        run_op(2, 31, 2, 0, 32'h0, 5'h1F, 0, 4 * WPR + 2, 1'b0, "R9 overflow b8");
        // R10/R12: start and host write ignored while busy
        run_op(1, 4, 8, 0, 32'h0000_0003, 5'd0, 0, 3 * 4 * WPR, 1'b1, "R10 R12 ignored busy");
        // err cleared by next accepted start
        run_op(3, 5, 0, 0, 32'h0, 5'h10, 1, 3, 1'b0, "R9 err clears");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule